// File: doc/BRIEF.md
# Serial ADC Conversion Interface

This block is the digital device side of a four-wire serial analog-to-digital converter. It works with a digital stand-in for the analog path. A host lowers chip select, clocks in an eight-bit control word on the serial input and keeps toggling the serial clock. The block opens the sampler's acquisition window partway through the control word and closes it when the word completes. It then raises a one-period strobe and runs a twelve-step successive-approximation search, one decision per serial-clock falling edge. Each decided bit goes out on the serial output as soon as it is known. The trial code sits on `dac_code`, and an external comparator model answers on `cmp_in`.

All pins are sampled into the fast system clock domain through a synchronizer. Every output is a register, so a port reacts a few system clocks after the serial-clock edge that causes it. High impedance is shown by an enable port per output: while the enable is low, the data output is held at zero. Only the mode in which the serial clock paces the conversion is built.

Top module: `serial_adc_if`

## Requirements
- R1: Serial input bits are taken on rising serial-clock edges only while `cs_n` is low. Edges seen with `cs_n` high change no state.
- R2: A control word begins at the first 1 on `din` after `cs_n` falls, and earlier zeros are skipped. After its eighth bit, `cfg_word` holds the word with the start bit in bit 7.
- R3: `th_acq` rises at the falling edge after the fifth control bit and falls at the falling edge after the eighth bit, so acquisition lasts three serial-clock periods.
- R4: `th_hold` rises after the eighth control bit and falls at the falling edge that makes the last (LSB) decision. At that point the sampler is back to tracking. `th_acq` and `th_hold` are never high together.
- R5: `strobe` is high for exactly one serial-clock period: from the falling edge after the eighth control bit to the next falling edge, which makes the MSB decision.
- R6: `dac_code` presents a trial code with the bit under test set. Each falling edge during conversion decides one bit, MSB first, and keeps it when `cmp_in` is 1. After twelve decisions, `result` holds the final code.
- R7: `dout` changes only after falling edges. It is 0 before the MSB, carries each decided bit from its decision edge, and returns to 0 at the first falling edge after the LSB.
- R8: While `cs_n` is high, `dout_oe` and `strobe_oe` are 0, and `dout` and `strobe` are 0.
- R9: Raising `cs_n` during a control word or a conversion returns the block to idle, clearing acquisition, hold and strobe. `result` keeps the last completed value.
- R10: `din` is ignored while a conversion runs. With `cs_n` held low, a new control word may begin on the first rising edge after the LSB decision.
- R11: If `cs_n` rises in the same system clock as the serial-clock fall that would make the LSB decision, the abort wins and `result` is unchanged.
- R12: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| din | input | 1 | Serial control input |
| cmp_in | input | 1 | Comparator answer for the current `dac_code` (1 = keep bit) |
| dout | output | 1 | Serial result output |
| dout_oe | output | 1 | Drive enable for `dout` |
| strobe | output | 1 | Conversion strobe |
| strobe_oe | output | 1 | Drive enable for `strobe` |
| th_acq | output | 1 | Sampler acquisition window |
| th_hold | output | 1 | Sampler hold (conversion running) |
| dac_code | output | RES | Current trial code |
| result | output | RES | Last completed conversion |
| cfg_word | output | CW | Last complete control word |

## Verification
Two functions can land in the same system clock: the final LSB decision, which commits `result`, and the chip-select abort. The bench provokes this by lowering `sclk` and raising `cs_n` in the same system-clock cycle at the twelfth conversion step. Because both pins pass through the same synchronizer, they reach the logic together. The bench judges the outcome by `result` still holding the previous conversion's value, with `th_hold` and `dout_oe` low afterwards. A second overlap is a new start bit right after the LSB while `din` was held high throughout the conversion. This is judged by the timing of `cfg_word` and of `th_acq`.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  typedef enum logic [0:0] {
    SAR_IDLE = 1'b0,
    SAR_RUN  = 1'b1
  } sar_state_t;

  // reset value of the synchronized pin bundle {cs_n, sclk, din}
  localparam logic [2:0] PIN_RST = 3'b100;
endpackage

// File: rtl/sadc_sync.sv
module sadc_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] nxt;
    if (s == 0) begin : g_first
      assign nxt = d_async;
    end else begin : g_rest
      assign nxt = chain[s-1];
    end
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= RST_VAL;
      else     chain[s] <= nxt;
    end
  end

  assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/sadc_ctl_rx.sv
module sadc_ctl_rx #(
  parameter int CW       = 8,
  parameter int TRACK_AT = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          abort,
  input  logic          sclk_rise,
  input  logic          sclk_fall,
  input  logic          din,
  input  logic          busy,
  output logic          acq,
  output logic          start_conv,
  output logic [CW-1:0] cfg_word
);
  localparam int CNT_W = $clog2(CW + 1);

  logic [CNT_W-1:0] cnt;
  logic [CW-1:0]    shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      shreg      <= '0;
      acq        <= 1'b0;
      start_conv <= 1'b0;
      cfg_word   <= '0;
    end else if (abort) begin
      cnt        <= '0;
      shreg      <= '0;
      acq        <= 1'b0;
      start_conv <= 1'b0;
    end else begin
      start_conv <= 1'b0;
      if (sclk_rise && !busy) begin
        if (cnt == '0) begin
          if (din) begin
            shreg <= {{(CW-1){1'b0}}, 1'b1};
            cnt   <= CNT_W'(1);
          end
        end else if (cnt < CNT_W'(CW)) begin
          shreg <= {shreg[CW-2:0], din};
          cnt   <= cnt + CNT_W'(1);
        end
      end
      if (sclk_fall) begin
        if (cnt == CNT_W'(TRACK_AT)) acq <= 1'b1;
        if (cnt == CNT_W'(CW)) begin
          acq        <= 1'b0;
          start_conv <= 1'b1;
          cfg_word   <= shreg;
          cnt        <= '0;
        end
      end
    end
  end

  // R3
  acq_open_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(acq) |-> $past(sclk_fall));

  // R3
  start_after_acq_chk: assert property (@(posedge clk) disable iff (rst)
    start_conv |-> $past(acq));
endmodule

// File: rtl/sadc_sar.sv
module sadc_sar
  import sadc_pkg::*;
#(
  parameter int RES = 12
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           abort,
  input  logic           sclk_fall,
  input  logic           start,
  input  logic           cmp_in,
  output logic           hold,
  output logic           strobe,
  output logic           busy,
  output logic [RES-1:0] dac_code,
  output logic [RES-1:0] result,
  output logic           dec_valid,
  output logic           dec_bit
);
  localparam int IW = $clog2(RES);

  sar_state_t     state;
  logic [IW-1:0]  idx;
  logic [RES-1:0] acc;

  always_comb begin
    acc = cmp_in ? dac_code : (dac_code & ~(RES'(1) << idx));
  end

  assign busy = (state == SAR_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SAR_IDLE;
      hold      <= 1'b0;
      strobe    <= 1'b0;
      idx       <= '0;
      dac_code  <= '0;
      result    <= '0;
      dec_valid <= 1'b0;
      dec_bit   <= 1'b0;
    end else begin
      dec_valid <= 1'b0;
      if (abort) begin
        state    <= SAR_IDLE;
        hold     <= 1'b0;
        strobe   <= 1'b0;
        idx      <= '0;
        dac_code <= '0;
        dec_bit  <= 1'b0;
      end else if (state == SAR_IDLE) begin
        if (start) begin
          state    <= SAR_RUN;
          hold     <= 1'b1;
          strobe   <= 1'b1;
          idx      <= IW'(RES-1);
          dac_code <= RES'(1) << (RES-1);
        end
      end else if (sclk_fall) begin
        strobe    <= 1'b0;
        dec_valid <= 1'b1;
        dec_bit   <= cmp_in;
        if (idx == '0) begin
          result   <= acc;
          state    <= SAR_IDLE;
          hold     <= 1'b0;
          dac_code <= '0;
        end else begin
          idx      <= idx - IW'(1);
          dac_code <= acc | (RES'(1) << (idx - IW'(1)));
        end
      end
    end
  end

  // R5
  strobe_in_hold_chk: assert property (@(posedge clk) disable iff (rst)
    strobe |-> hold);

  // R6
  result_on_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (result != $past(result)) |-> $past(sclk_fall));
endmodule

// File: rtl/sadc_tx.sv
module sadc_tx (
  input  logic clk,
  input  logic rst,
  input  logic cs_hi,
  input  logic sclk_fall,
  input  logic busy,
  input  logic dec_valid,
  input  logic dec_bit,
  input  logic strobe_in,
  output logic dout,
  output logic dout_oe,
  output logic strobe_out,
  output logic strobe_oe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dout       <= 1'b0;
      dout_oe    <= 1'b0;
      strobe_out <= 1'b0;
      strobe_oe  <= 1'b0;
    end else begin
      dout_oe    <= ~cs_hi;
      strobe_oe  <= ~cs_hi;
      strobe_out <= strobe_in & ~cs_hi;
      if (cs_hi)                   dout <= 1'b0;
      else if (dec_valid)          dout <= dec_bit;
      else if (sclk_fall && !busy) dout <= 1'b0;
    end
  end

  // R8
  oe_follows_cs_chk: assert property (@(posedge clk) disable iff (rst)
    cs_hi |=> (!dout_oe && !strobe_oe));

  // R8
  quiet_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    !dout_oe |-> (!dout && !strobe_out));

  // R7
  dout_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (dout != $past(dout)) |-> $past(dec_valid || sclk_fall || cs_hi));
endmodule

// File: rtl/serial_adc_if.sv
module serial_adc_if
  import sadc_pkg::*;
#(
  parameter int RES         = 12,
  parameter int CW          = 8,
  parameter int TRACK_AT    = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           sclk,
  input  logic           cs_n,
  input  logic           din,
  input  logic           cmp_in,
  output logic           dout,
  output logic           dout_oe,
  output logic           strobe,
  output logic           strobe_oe,
  output logic           th_acq,
  output logic           th_hold,
  output logic [RES-1:0] dac_code,
  output logic [RES-1:0] result,
  output logic [CW-1:0]  cfg_word
);
  logic [2:0] pins_s;
  logic       cs_s, sclk_s, din_s, sclk_d;
  logic       sclk_rise, sclk_fall;
  logic       start_conv, busy, sar_strobe, dec_valid, dec_bit;

  sadc_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
    .clk(clk), .rst(rst), .d_async({cs_n, sclk, din}), .d_sync(pins_s)
  );
  assign {cs_s, sclk_s, din_s} = pins_s;

  always_ff @(posedge clk) begin
    if (rst) sclk_d <= 1'b0;
    else     sclk_d <= sclk_s;
  end

  assign sclk_rise = sclk_s & ~sclk_d & ~cs_s;
  assign sclk_fall = ~sclk_s & sclk_d & ~cs_s;

  sadc_ctl_rx #(.CW(CW), .TRACK_AT(TRACK_AT)) u_ctl (
    .clk(clk), .rst(rst), .abort(cs_s),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .din(din_s), .busy(busy),
    .acq(th_acq), .start_conv(start_conv), .cfg_word(cfg_word)
  );

  sadc_sar #(.RES(RES)) u_sar (
    .clk(clk), .rst(rst), .abort(cs_s), .sclk_fall(sclk_fall),
    .start(start_conv), .cmp_in(cmp_in),
    .hold(th_hold), .strobe(sar_strobe), .busy(busy),
    .dac_code(dac_code), .result(result),
    .dec_valid(dec_valid), .dec_bit(dec_bit)
  );

  sadc_tx u_tx (
    .clk(clk), .rst(rst), .cs_hi(cs_s), .sclk_fall(sclk_fall), .busy(busy),
    .dec_valid(dec_valid), .dec_bit(dec_bit), .strobe_in(sar_strobe),
    .dout(dout), .dout_oe(dout_oe), .strobe_out(strobe), .strobe_oe(strobe_oe)
  );

  // R4
  acq_hold_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(th_acq && th_hold));

  // R4
  hold_after_acq_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(th_hold) |-> $past(th_acq, 2));

  // R9
  abort_idle_chk: assert property (@(posedge clk) disable iff (rst)
    cs_s |=> (!th_acq && !th_hold));
endmodule

// File: tb/serial_adc_if_tb_top.sv
`timescale 1ns/1ps
module serial_adc_if_tb_top;
  localparam int RES = 12;
  localparam int CW  = 8;
  localparam int H   = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0;
  logic cs_n = 1'b1;
  logic din = 1'b0;
  logic cmp_in;
  logic dout, dout_oe, strobe, strobe_oe, th_acq, th_hold;
  logic [RES-1:0] dac_code, result;
  logic [CW-1:0]  cfg_word;
  logic [RES-1:0] vin = '0;
  logic [RES-1:0] exp_result = '0;
  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  // comparator stand-in: keep the bit while the trial does not exceed the input
  assign cmp_in = (dac_code <= vin);

  serial_adc_if dut_i (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .din(din), .cmp_in(cmp_in),
    .dout(dout), .dout_oe(dout_oe), .strobe(strobe), .strobe_oe(strobe_oe),
    .th_acq(th_acq), .th_hold(th_hold), .dac_code(dac_code), .result(result),
    .cfg_word(cfg_word)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one serial clock period; ends late in the low phase after the fall
  task automatic cyc(input logic b);
    din = b;
    idle(H);
    sclk = 1'b1;
    idle(H);
    sclk = 1'b0;
    idle(H);
  endtask

  task automatic send_ctrl(input int lead, input logic [7:0] c);
    for (int i = 0; i < lead; i++) cyc(1'b0);
    if (lead > 0) chk("R2 leading zeros open nothing", th_acq, 0);
    for (int i = 0; i < CW; i++) begin
      cyc(c[7-i]);
      if (i == 3) chk("R3 no acq before fifth bit", th_acq, 0);
      if (i == 4) chk("R3 acq after fifth bit", th_acq, 1);
      if (i == 6) chk("R3 acq still open", th_acq, 1);
    end
    chk("R3 acq closed after eighth bit", th_acq, 0);
    chk("R4 hold after eighth bit", th_hold, 1);
    chk("R5 strobe before MSB", strobe, 1);
    chk("R7 leading zero on dout", dout, 0);
    chk("R2 cfg_word", cfg_word, c);
  endtask

  task automatic conv_steps(input int n, input logic conv_din);
    for (int k = 0; k < n; k++) begin
      cyc(conv_din);
      chk("R7 dout decided bit", dout, vin[RES-1-k]);
      if (k == 0) chk("R5 strobe one period", strobe, 0);
      if (k == 5) chk("R4 hold during conversion", th_hold, 1);
      if (k == RES-1) begin
        chk("R4 track after LSB", th_hold, 0);
        chk("R6 result", result, vin);
        exp_result = vin;
      end
    end
  endtask

  task automatic frame(input logic [RES-1:0] v, input int lead, input logic [7:0] c,
                       input logic conv_din);
    vin = v;
    send_ctrl(lead, c);
    conv_steps(RES, conv_din);
  endtask

  task automatic t_reset();
    chk("R12 dout_oe", dout_oe, 0);
    chk("R12 strobe_oe", strobe_oe, 0);
    chk("R12 acq", th_acq, 0);
    chk("R12 hold", th_hold, 0);
    chk("R12 result", result, 0);
    chk("R12 dout", dout, 0);
  endtask

  task automatic t_cs_high();
    cs_n = 1'b1;
    for (int i = 0; i < 10; i++) cyc(1'b1);
    chk("R1 no acq with cs high", th_acq, 0);
    chk("R1 no hold with cs high", th_hold, 0);
    chk("R1 cfg_word untouched", cfg_word, 0);
    chk("R8 dout_oe off", dout_oe, 0);
    chk("R8 strobe_oe off", strobe_oe, 0);
  endtask

  task automatic t_basic();
    cs_n = 1'b0;
    idle(H);
    chk("R8 dout_oe on", dout_oe, 1);
    chk("R8 strobe_oe on", strobe_oe, 1);
    frame(12'hA5C, 3, 8'b1000_1111, 1'b0);
    cyc(1'b0);
    chk("R7 zero fill after LSB", dout, 0);
    cs_n = 1'b1;
    idle(2*H);
    chk("R8 dout_oe off after frame", dout_oe, 0);
    chk("R8 dout quiet", dout, 0);
  endtask

  task automatic t_bounds();
    logic [RES-1:0] vals [4] = '{12'hFFF, 12'h000, 12'h001, 12'h800};
    for (int j = 0; j < 4; j++) begin
      cs_n = 1'b0;
      idle(H);
      frame(vals[j], j, 8'hF0 | 8'(j), 1'b0);
      cs_n = 1'b1;
      idle(2*H);
    end
  endtask

  task automatic t_back2back();
    cs_n = 1'b0;
    idle(H);
    frame(12'h3C7, 1, 8'hC5, 1'b1);
    chk("R10 din ignored in conversion", th_acq, 0);
    frame(12'h5A1, 0, 8'h9A, 1'b1);
    chk("R10 second word accepted", cfg_word, 8'h9A);
    cs_n = 1'b1;
    idle(2*H);
  endtask

  task automatic t_abort();
    cs_n = 1'b0;
    idle(H);
    vin = 12'h777;
    send_ctrl(2, 8'hA3);
    conv_steps(5, 1'b0);
    cs_n = 1'b1;
    idle(2*H);
    chk("R9 hold cleared", th_hold, 0);
    chk("R9 strobe cleared", strobe, 0);
    chk("R9 result kept", result, exp_result);
    cs_n = 1'b0;
    idle(H);
    for (int i = 0; i < 6; i++) cyc(1'b1);
    chk("R9 acq open mid-word", th_acq, 1);
    cs_n = 1'b1;
    idle(2*H);
    chk("R9 acq cleared", th_acq, 0);
    cs_n = 1'b0;
    idle(H);
    frame(12'h123, 0, 8'h81, 1'b0);
    cs_n = 1'b1;
    idle(2*H);
  endtask

  task automatic t_same_cycle();
    cs_n = 1'b0;
    idle(H);
    vin = 12'h9E4;
    send_ctrl(0, 8'hE2);
    conv_steps(RES-1, 1'b0);
    din = 1'b0;
    idle(H);
    sclk = 1'b1;
    idle(H);
    sclk = 1'b0;
    cs_n = 1'b1;
    idle(2*H);
    chk("R11 abort wins over LSB", result, exp_result);
    chk("R11 hold cleared", th_hold, 0);
    chk("R11 dout_oe off", dout_oe, 0);
  endtask

  initial begin
    idle(5);
    rst = 1'b0;
    idle(5);
    t_reset();
    t_cs_high();
    t_basic();
    t_bounds();
    t_back2back();
    t_abort();
    t_same_cycle();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule